// File: doc/BRIEF.md
# Associative Line Buffer with LRU Replacement

This block is a small, fully associative staging buffer placed between a load/store path and a data cache. Every request carries a physical address that has already been translated. The line part of that address is compared against the tags of all resident lines at once. A hit is served locally. A load returns one 64-bit word in the next cycle. A store merges its enabled bytes into the line and marks those bytes dirty.

When no tag matches, the buffer picks the least recently used line as the victim. It reports the victim's index for one cycle, so that logic elsewhere can drop any pointer state tied to that line. If the victim holds modified bytes, the buffer pushes them to the cache side together with a byte mask. It then requests the new line, and it stays busy until the refill data arrives. The pending load or store completes on the refilled line.

A line can only be filled after a failed lookup. For this reason an address never sits in two lines, even when several pointers name it.

Top module: `assoc_line_buffer`

## Requirements
- R1: After reset, busy, rsp_valid, evict_valid, wb_valid and fill_req are all 0 and no line is valid.
- R2: A load that hits (req_valid=1, req_write=0, busy=0) raises rsp_valid one cycle later. rsp_rdata then holds the word selected by req_addr[4:3], with byte b of the word taken from line byte 8*req_addr[4:3]+b.
- R3: At most one line matches any address. A request to a resident line hits: it causes no eviction and does not raise busy.
- R4: On a miss, the victim is the least recently used line. Line 0 counts as most recent at reset, so successive misses from reset fill lines 7, 6, ..., 0.
- R5: Every hit, and every completed refill, makes the accessed line the most recent. Lines more recent than it age by one place, and older lines keep their place.
- R6: In the cycle after a miss is accepted, evict_valid pulses for exactly one cycle and evict_idx carries the victim index.
- R7: A store writes only the bytes whose req_be bit is 1 (req_be[b] covers bit range 8b+7:8b of req_wdata) and leaves all other bytes of the line unchanged.
- R8: If the victim has dirty bytes, wb_valid pulses in the same cycle as evict_valid. wb_addr is then the victim's line address with bits [4:0] zero, wb_data is the whole line, and wb_mask bit k is 1 exactly when line byte k was stored since the fill. A clean victim raises no wb_valid.
- R9: One cycle after the eviction pulse, fill_req pulses with the line-aligned request address. busy stays 1 until the cycle after fill_valid. The pending load then answers from the refilled data, or the pending store merges into the refilled data.
- R10: Requests presented while busy is 1 are ignored and change no line.
- R11: A load to the same line in the cycle right after a store returns the stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Translated byte address |
| req_be | input | WORD_BYTES | Store byte enables |
| req_wdata | input | 8*WORD_BYTES | Store data |
| busy | output | 1 | Miss in progress; requests ignored |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 8*WORD_BYTES | Load data |
| evict_valid | output | 1 | One-cycle victim report |
| evict_idx | output | log2(LINES) | Index of the replaced line |
| wb_valid | output | 1 | Write-back of a dirty victim |
| wb_addr | output | AW | Line address of the write-back |
| wb_data | output | 8*LINE_BYTES | Victim line contents |
| wb_mask | output | LINE_BYTES | Dirty byte mask of the victim |
| fill_req | output | 1 | Refill request pulse |
| fill_addr | output | AW | Line address to refill |
| fill_valid | input | 1 | Refill data present |
| fill_data | input | 8*LINE_BYTES | Refill line contents |

## Verification
The assertions check on every cycle the properties that need no data model. No address ever matches two lines. Exactly one line holds the oldest age. An eviction pulse lasts one cycle and is followed by busy. A write-back only accompanies an eviction and always has a non-empty mask. A refill request always follows an eviction, and busy only drops after refill data.

Only the bench scenarios can show the data-dependent behaviour. These include which line the LRU order picks after a given history of hits, the exact bytes a partial store leaves behind, and the contents of a write-back and of a line re-fetched after it. They also show that a request made while busy leaves no trace, and that a load in the cycle after a store sees the new bytes.

// File: rtl/alb_pkg.sv
package alb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } alb_state_e;
endpackage

// File: rtl/alb_tag_match.sv
module alb_tag_match #(
  parameter int LINES = 8,
  parameter int TAG_W = 27
) (
  input  logic [LINES-1:0][TAG_W-1:0] line_tag,
  input  logic [LINES-1:0]            line_valid,
  input  logic [TAG_W-1:0]            lookup_tag,
  output logic [LINES-1:0]            hit_vec,
  output logic                        hit,
  output logic [$clog2(LINES)-1:0]    hit_idx
);
  localparam int IDX_W = $clog2(LINES);

  // one comparator per resident line, all in parallel
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign hit_vec[i] = line_valid[i] && (line_tag[i] == lookup_tag);
  end

  assign hit = |hit_vec;

  // OR-encoder: valid because fills only happen after a failed lookup
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/alb_lru.sv
module alb_lru #(
  parameter int LINES = 8
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   touch_en,
  input  logic [$clog2(LINES)-1:0]               touch_idx,
  output logic [$clog2(LINES)-1:0]               victim_idx,
  output logic [LINES-1:0][$clog2(LINES)-1:0]    ages
);
  localparam int IDX_W = $clog2(LINES);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(LINES - 1);

  logic [LINES-1:0][IDX_W-1:0] age_q;
  logic [IDX_W-1:0]            touched_age;

  assign touched_age = age_q[touch_idx];
  assign ages        = age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LINES; j++) age_q[j] <= IDX_W'(j);
    end else if (touch_en) begin
      for (int j = 0; j < LINES; j++) begin
        if (IDX_W'(j) == touch_idx)     age_q[j] <= '0;
        else if (age_q[j] < touched_age) age_q[j] <= age_q[j] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int j = 0; j < LINES; j++) begin
      if (age_q[j] == OLDEST) victim_idx = IDX_W'(j);
    end
  end
endmodule

// File: rtl/assoc_line_buffer.sv
module assoc_line_buffer
  import alb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic [AW-1:0]              req_addr,
  input  logic [WORD_BYTES-1:0]      req_be,
  input  logic [8*WORD_BYTES-1:0]    req_wdata,
  output logic                       busy,
  output logic                       rsp_valid,
  output logic [8*WORD_BYTES-1:0]    rsp_rdata,
  output logic                       evict_valid,
  output logic [$clog2(LINES)-1:0]   evict_idx,
  output logic                       wb_valid,
  output logic [AW-1:0]              wb_addr,
  output logic [8*LINE_BYTES-1:0]    wb_data,
  output logic [LINE_BYTES-1:0]      wb_mask,
  output logic                       fill_req,
  output logic [AW-1:0]              fill_addr,
  input  logic                       fill_valid,
  input  logic [8*LINE_BYTES-1:0]    fill_data
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BO_W   = $clog2(WORD_BYTES);
  localparam int IDX_W  = $clog2(LINES);
  localparam int WSEL_W = OFF_W - BO_W;
  localparam int TAG_W  = AW - OFF_W;
  localparam int LINE_W = 8 * LINE_BYTES;
  localparam int WORD_W = 8 * WORD_BYTES;

  // storage
  logic [LINE_W-1:0]                line_mem [LINES];
  logic [LINES-1:0][TAG_W-1:0]      tag_q;
  logic [LINES-1:0]                 valid_q;
  logic [LINES-1:0][LINE_BYTES-1:0] dirty_q;
  alb_state_e                       state_q;

  // request held across a miss
  logic                  p_write;
  logic [TAG_W-1:0]      p_tag;
  logic [WSEL_W-1:0]     p_ws;
  logic [WORD_BYTES-1:0] p_be;
  logic [WORD_W-1:0]     p_wdata;
  logic [IDX_W-1:0]      p_victim;

  logic [TAG_W-1:0]  req_tag;
  logic [WSEL_W-1:0] req_ws;
  logic              unused_lowbits;
  logic [LINES-1:0]  hit_vec;
  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic [LINES-1:0][IDX_W-1:0] lru_ages;
  logic acc, hit_acc, miss_acc, fill_done, touch_en;
  logic [IDX_W-1:0]  touch_idx;

  assign req_tag        = req_addr[AW-1:OFF_W];
  assign req_ws         = req_addr[OFF_W-1:BO_W];
  assign unused_lowbits = ^req_addr[BO_W-1:0];

  assign acc       = req_valid && (state_q == ST_IDLE);
  assign hit_acc   = acc && hit;
  assign miss_acc  = acc && !hit;
  assign fill_done = (state_q == ST_WAIT) && fill_valid;
  assign touch_en  = hit_acc || fill_done;
  assign touch_idx = hit_acc ? hit_idx : p_victim;

  function automatic logic [LINE_W-1:0] merge_word(
    input logic [LINE_W-1:0]     line,
    input logic [WSEL_W-1:0]     ws,
    input logic [WORD_BYTES-1:0] be,
    input logic [WORD_W-1:0]     wd
  );
    logic [LINE_W-1:0] r;
    r = line;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if (be[b]) r[(int'(ws) * WORD_BYTES + b) * 8 +: 8] = wd[b * 8 +: 8];
    end
    return r;
  endfunction

  function automatic logic [LINE_BYTES-1:0] byte_mask(
    input logic [WSEL_W-1:0]     ws,
    input logic [WORD_BYTES-1:0] be
  );
    return LINE_BYTES'(be) << (int'(ws) * WORD_BYTES);
  endfunction

  alb_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
    .line_tag   (tag_q),
    .line_valid (valid_q),
    .lookup_tag (req_tag),
    .hit_vec    (hit_vec),
    .hit        (hit),
    .hit_idx    (hit_idx)
  );

  alb_lru #(.LINES(LINES)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch_en   (touch_en),
    .touch_idx  (touch_idx),
    .victim_idx (victim_idx),
    .ages       (lru_ages)
  );

  // line data: one write port, no reset
  always_ff @(posedge clk) begin
    if (hit_acc && req_write) begin
      line_mem[hit_idx] <= merge_word(line_mem[hit_idx], req_ws, req_be, req_wdata);
    end else if (fill_done) begin
      line_mem[p_victim] <= p_write ? merge_word(fill_data, p_ws, p_be, p_wdata)
                                    : fill_data;
    end
  end

  // control, tags and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      busy        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      evict_valid <= 1'b0;
      evict_idx   <= '0;
      wb_valid    <= 1'b0;
      wb_addr     <= '0;
      wb_data     <= '0;
      wb_mask     <= '0;
      fill_req    <= 1'b0;
      fill_addr   <= '0;
      tag_q       <= '0;
      valid_q     <= '0;
      dirty_q     <= '0;
      p_write     <= 1'b0;
      p_tag       <= '0;
      p_ws        <= '0;
      p_be        <= '0;
      p_wdata     <= '0;
      p_victim    <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      evict_valid <= 1'b0;
      wb_valid    <= 1'b0;
      fill_req    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (hit_acc) begin
            if (req_write) begin
              dirty_q[hit_idx] <= dirty_q[hit_idx] | byte_mask(req_ws, req_be);
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= line_mem[hit_idx][int'(req_ws) * WORD_W +: WORD_W];
            end
          end else if (miss_acc) begin
            p_write     <= req_write;
            p_tag       <= req_tag;
            p_ws        <= req_ws;
            p_be        <= req_be;
            p_wdata     <= req_wdata;
            p_victim    <= victim_idx;
            evict_valid <= 1'b1;
            evict_idx   <= victim_idx;
            wb_valid    <= valid_q[victim_idx] && (|dirty_q[victim_idx]);
            wb_addr     <= {tag_q[victim_idx], {OFF_W{1'b0}}};
            wb_data     <= line_mem[victim_idx];
            wb_mask     <= dirty_q[victim_idx];
            valid_q[victim_idx] <= 1'b0;
            busy        <= 1'b1;
            state_q     <= ST_REQ;
          end
        end
        ST_REQ: begin
          fill_req  <= 1'b1;
          fill_addr <= {p_tag, {OFF_W{1'b0}}};
          state_q   <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fill_valid) begin
            tag_q[p_victim]   <= p_tag;
            valid_q[p_victim] <= 1'b1;
            dirty_q[p_victim] <= p_write ? byte_mask(p_ws, p_be) : '0;
            if (!p_write) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= fill_data[int'(p_ws) * WORD_W +: WORD_W];
            end
            busy    <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/alb_checker.sv
module alb_checker #(
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 32
) (
  input logic                                clk,
  input logic                                rst,
  input logic [LINES-1:0]                    hit_vec,
  input logic [LINES-1:0][$clog2(LINES)-1:0] ages,
  input logic                                evict_valid,
  input logic                                wb_valid,
  input logic [LINE_BYTES-1:0]               wb_mask,
  input logic                                fill_req,
  input logic                                fill_valid,
  input logic                                busy
);
  localparam int IDX_W = $clog2(LINES);
  logic [LINES-1:0] oldest_vec;

  for (genvar i = 0; i < LINES; i++) begin : g_old
    assign oldest_vec[i] = (ages[i] == IDX_W'(LINES - 1));
  end

  assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  assert_one_oldest_R4: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest_vec) == 1);

  assert_evict_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    evict_valid |=> !evict_valid);

  assert_evict_busy_R6: assert property (@(posedge clk) disable iff (rst)
    evict_valid |=> busy);

  assert_wb_with_evict_R8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (evict_valid && (wb_mask != '0)));

  assert_fill_after_evict_R9: assert property (@(posedge clk) disable iff (rst)
    fill_req |-> $past(evict_valid));

  assert_busy_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(fill_valid));
endmodule

bind assoc_line_buffer alb_checker #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .hit_vec     (hit_vec),
  .ages        (lru_ages),
  .evict_valid (evict_valid),
  .wb_valid    (wb_valid),
  .wb_mask     (wb_mask),
  .fill_req    (fill_req),
  .fill_valid  (fill_valid),
  .busy        (busy)
);

// File: tb/assoc_line_buffer_tb.sv
module assoc_line_buffer_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [31:0]  req_addr = '0;
  logic [7:0]   req_be = '0;
  logic [63:0]  req_wdata = '0;
  logic         busy, rsp_valid, evict_valid, wb_valid, fill_req;
  logic [63:0]  rsp_rdata;
  logic [2:0]   evict_idx;
  logic [31:0]  wb_addr, fill_addr;
  logic [255:0] wb_data;
  logic [31:0]  wb_mask;
  logic         fill_valid = 1'b0;
  logic [255:0] fill_data = '0;

  always #10 clk = ~clk;

  assoc_line_buffer u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_mask(wb_mask),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model
  logic [7:0]  mem [0:1023];
  logic [7:0]  mdata [0:7][0:31];
  logic [31:0] mdirty [0:7];
  int          mtag [0:7];
  bit          mval [0:7];
  int          ord [0:7];   // ord[0] most recent

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic int find_line(int t);
    for (int i = 0; i < 8; i++) if (mval[i] && mtag[i] == t) return i;
    return -1;
  endfunction

  function automatic logic [255:0] model_line(int v);
    logic [255:0] r;
    for (int b = 0; b < 32; b++) r[b*8 +: 8] = mdata[v][b];
    return r;
  endfunction

  function automatic logic [63:0] model_word(int v, int ws);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = mdata[v][ws*8 + b];
    return r;
  endfunction

  task automatic touch(int v);
    int pos = 0;
    for (int i = 0; i < 8; i++) if (ord[i] == v) pos = i;
    for (int i = pos; i > 0; i--) ord[i] = ord[i-1];
    ord[0] = v;
  endtask

  task automatic model_store(int v, int ws, logic [7:0] be, logic [63:0] wd);
    for (int b = 0; b < 8; b++) begin
      if (be[b]) begin
        mdata[v][ws*8 + b] = wd[b*8 +: 8];
        mdirty[v][ws*8 + b] = 1'b1;
      end
    end
  endtask

  // drive one access at the current time (just after a falling edge)
  task automatic access(input bit wr, input logic [31:0] addr, input logic [7:0] be,
                        input logic [63:0] wd, input string tag,
                        input bit inject, input logic [31:0] inj_addr);
    int t = int'(addr >> 5);
    int ws = int'(addr[4:3]);
    int h = find_line(t);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    if (h >= 0) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk(!evict_valid && !busy, "R3", "hit caused eviction/busy",
          {254'd0, evict_valid, busy}, 256'd0);
      if (wr) model_store(h, ws, be, wd);
      else chk(rsp_valid && rsp_rdata == model_word(h, ws), tag, "hit load data",
               {191'd0, rsp_valid, rsp_rdata}, {191'd0, 1'b1, model_word(h, ws)});
      touch(h);
    end else begin
      int v = ord[7];
      logic [255:0] fd;
      @(negedge clk);
      if (inject) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = inj_addr;
        req_be = 8'hFF; req_wdata = 64'hDEAD_BEEF_0BAD_F00D;
      end else req_valid = 1'b0;
      chk(evict_valid && evict_idx == 3'(v), "R4 R5 R6", "victim index",
          {252'd0, evict_valid, evict_idx}, {252'd0, 1'b1, 3'(v)});
      chk(busy, "R9", "busy after miss", {255'd0, busy}, 256'd1);
      if (mval[v] && mdirty[v] != 0) begin
        chk(wb_valid, "R8", "write-back pulse", {255'd0, wb_valid}, 256'd1);
        chk(wb_addr == 32'(mtag[v] << 5), "R8", "write-back addr",
            {224'd0, wb_addr}, {224'd0, 32'(mtag[v] << 5)});
        chk(wb_mask == mdirty[v], "R8", "write-back mask",
            {224'd0, wb_mask}, {224'd0, mdirty[v]});
        chk(wb_data == model_line(v), "R8 R7", "write-back data", wb_data, model_line(v));
        for (int b = 0; b < 32; b++) if (wb_mask[b]) mem[mtag[v]*32 + b] = wb_data[b*8 +: 8];
      end else begin
        chk(!wb_valid, "R8", "clean victim wrote back", {255'd0, wb_valid}, 256'd0);
      end
      @(negedge clk);
      chk(fill_req && fill_addr == 32'(t << 5), "R9", "fill request",
          {223'd0, fill_req, fill_addr}, {223'd0, 1'b1, 32'(t << 5)});
      chk(busy, "R9", "busy while waiting", {255'd0, busy}, 256'd1);
      for (int b = 0; b < 32; b++) fd[b*8 +: 8] = mem[t*32 + b];
      @(negedge clk);   // refill arrives a cycle later
      chk(busy, "R9", "busy until refill", {255'd0, busy}, 256'd1);
      fill_valid = 1'b1; fill_data = fd;
      @(negedge clk);
      fill_valid = 1'b0; req_valid = 1'b0;
      chk(!busy, "R9", "busy released", {255'd0, busy}, 256'd0);
      mval[v] = 1'b1; mtag[v] = t; mdirty[v] = '0;
      for (int b = 0; b < 32; b++) mdata[v][b] = fd[b*8 +: 8];
      if (wr) model_store(v, ws, be, wd);
      else chk(rsp_valid && rsp_rdata == model_word(v, ws), tag, "miss load data",
               {191'd0, rsp_valid, rsp_rdata}, {191'd0, 1'b1, model_word(v, ws)});
      touch(v);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 37 + 11) & 255);
    for (int i = 0; i < 8; i++) begin
      ord[i] = i; mval[i] = 1'b0; mtag[i] = -1; mdirty[i] = '0;
      for (int b = 0; b < 32; b++) mdata[i][b] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1", "busy", {255'd0, busy}, 256'd0);
    chk(!rsp_valid, "R1", "rsp_valid", {255'd0, rsp_valid}, 256'd0);
    chk(!evict_valid, "R1", "evict_valid", {255'd0, evict_valid}, 256'd0);
    chk(!wb_valid, "R1", "wb_valid", {255'd0, wb_valid}, 256'd0);
    chk(!fill_req, "R1", "fill_req", {255'd0, fill_req}, 256'd0);

    // fill every line from reset: victims 7..0 (R4)
    for (int l = 0; l < 8; l++) access(1'b0, 32'(l*32 + (l%4)*8), 8'h00, 64'd0, "R9", 1'b0, 32'd0);
    // hits on every word of every line, reordering recency (R2, R5)
    for (int l = 7; l >= 0; l--)
      for (int w = 0; w < 4; w++) access(1'b0, 32'(l*32 + w*8), 8'h00, 64'd0, "R2", 1'b0, 32'd0);
    for (int l = 0; l < 8; l += 3) access(1'b0, 32'(l*32), 8'h00, 64'd0, "R2", 1'b0, 32'd0);
    // partial stores, each followed next cycle by a load (R7, R11)
    for (int l = 0; l < 8; l++) begin
      logic [7:0] be = 8'(8'hA5 << l) | 8'(8'hA5 >> (8 - l));
      logic [31:0] a = 32'(l*32 + ((l+1)%4)*8);
      access(1'b1, a, be, 64'h0123_4567_89AB_CDEF ^ {8{8'(l)}}, "R7", 1'b0, 32'd0);
      access(1'b0, a, 8'h00, 64'd0, "R11", 1'b0, 32'd0);
      access(1'b0, 32'(l*32 + ((l+2)%4)*8), 8'h00, 64'd0, "R7", 1'b0, 32'd0);
    end
    // new lines evict the dirty ones (R8); requests during a miss ignored (R10)
    for (int l = 8; l < 16; l++) begin
      logic [31:0] inj = 32'(mtag[ord[0]] * 32 + 8);
      access(l[0], 32'(l*32 + (l%4)*8), 8'h3C, 64'hF0E1_D2C3_B4A5_9687 + 64'(l), "R9", l == 8, inj);
      if (l == 8) access(1'b0, inj, 8'h00, 64'd0, "R10", 1'b0, 32'd0);
    end
    // re-fetch written-back lines: data must round-trip (R8)
    for (int l = 0; l < 8; l++) access(1'b0, 32'(l*32 + ((l+1)%4)*8), 8'h00, 64'd0, "R8", 1'b0, 32'd0);
    // a miss store merged into the refill, read back (R9)
    access(1'b1, 32'(20*32 + 16), 8'hF0, 64'hAAAA_BBBB_CCCC_DDDD, "R9", 1'b0, 32'd0);
    access(1'b0, 32'(20*32 + 16), 8'h00, 64'd0, "R9", 1'b0, 32'd0);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule